// File: doc/BRIEF.md
# Per-Core Watchdog Pause and Second-Timeout Reset Control

This block is a memory-mapped register file that holds the software-visible watchdog policy for a cluster of processor cores. Each core owns a 32-byte register group on a simple single-cycle read/write bus. Inside each group, a control/status word holds two flags. A pause flag stops that core's watchdog. A reset-arm flag permits a core reset when the watchdog times out a second time. A read-only pointer word tells software where the watchdog counter registers of that core live, and which version they are.

The pause flag has a guarded set. Software sets it only by writing a fixed key into a write-only code field, and clears it by writing one to the flag. The reset-arm flag is write-one-to-set from software. Hardware clears it whenever the core's power-active input is low. Both flags leave the block as registered per-core outputs. These outputs feed the watchdog counter and the reset generator, which sit outside this block.

Top module: `wdog_core_ctl`

## Requirements
- R1: The group of core c starts at byte address c*0x20. Its control/status word is at group offset 0x04 and its pointer word at offset 0x08. Read data is combinational from the current address.
- R2: The pointer word of core c reads 0x78300 + 0x100*c in bits 20:0, a version of 000b in bits 23:21, and 0 above. Writes to it are ignored.
- R3: A write to the control/status word with bits 7:0 equal to 0x76 and bit 8 clear sets the pause flag at the next clock edge. The pause flag reads back in bit 8. Bits 7:0 always read 0.
- R4: A write to the control/status word with any code other than 0x76 and bit 8 clear leaves the pause flag unchanged.
- R5: A write to the control/status word with bit 8 set clears the pause flag at the next edge. This holds even when the same write carries code 0x76.
- R6: While the core is active, a write to the control/status word with bit 9 set sets the reset-arm flag at the next edge. A write with bit 9 clear leaves it unchanged. The flag reads back in bit 9.
- R7: When the core's active input is 0 at a clock edge, the reset-arm flag is 0 after that edge. This takes priority over a set write in the same cycle.
- R8: After a synchronous active-high reset, every pause and reset-arm flag is 0. The outputs pause_o[c] and arm_o[c] equal the flags of core c.
- R9: Every other address reads 0, and writes to it change no flag. This covers other group offsets and groups at or above NUM_CORES. A write to one core's group never changes another core's flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| core_active | input | NUM_CORES | Per-core power-active state |
| pause_o | output | NUM_CORES | Per-core watchdog pause |
| arm_o | output | NUM_CORES | Per-core second-timeout reset enable |

## Verification
A wrong pause or reset-arm flag shows at pause_o or arm_o one edge after the write that causes it. The same wrong flag shows on rdata as soon as the address points at that core's control/status word. A decoding fault shows in two ways. One is a flag changing in a core other than the addressed one. The other is a nonzero read from an unmapped address. Both appear the cycle after the write. The bench sweeps every code value and every address, so a single stray bit in decode or readback surfaces within a few cycles.

// File: rtl/wdog_core_ctl.sv
module wdog_core_ctl #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NUM_CORES-1:0] core_active,
  output logic [NUM_CORES-1:0] pause_o,
  output logic [NUM_CORES-1:0] arm_o
);

  localparam int          GRP_SH    = 5;
  localparam int          GRP_W     = ADDR_W - GRP_SH;
  localparam logic [4:0]  OFF_CTRL  = 5'h04;
  localparam logic [4:0]  OFF_PTR   = 5'h08;
  localparam logic [7:0]  PAUSE_KEY = 8'h76;
  localparam int          PTR_BASE  = 32'h78300;
  localparam int          PTR_STEP  = 32'h100;
  localparam logic [2:0]  VERSION   = 3'b000;

  logic [GRP_W-1:0]     grp;
  logic [4:0]           offs;
  logic [NUM_CORES-1:0] paused_q;
  logic [NUM_CORES-1:0] arm_q;
  logic                 unused_wdata;

  assign grp          = addr[ADDR_W-1:GRP_SH];
  assign offs         = addr[GRP_SH-1:0];
  assign unused_wdata = ^wdata[31:10];
  assign pause_o      = paused_q;
  assign arm_o        = arm_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic wr_ctrl;
    assign wr_ctrl = wr_en && (grp == GRP_W'(c)) && (offs == OFF_CTRL);

    always_ff @(posedge clk) begin
      if (rst)
        paused_q[c] <= 1'b0;
      else if (wr_ctrl && wdata[8])
        paused_q[c] <= 1'b0;
      else if (wr_ctrl && wdata[7:0] == PAUSE_KEY)
        paused_q[c] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)
        arm_q[c] <= 1'b0;
      else if (!core_active[c])
        arm_q[c] <= 1'b0;
      else if (wr_ctrl && wdata[9])
        arm_q[c] <= 1'b1;
    end

    // R3
    a_r3_key_sets_pause: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(c*32 + 4) && wdata[7:0] == 8'h76 && !wdata[8])
      |=> pause_o[c]);
    // R5
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(c*32 + 4) && wdata[8]) |=> !pause_o[c]);
    // R6
    a_r6_arm_set: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(c*32 + 4) && wdata[9] && core_active[c]) |=> arm_o[c]);
    // R7
    a_r7_inactive_clears: assert property (@(posedge clk) disable iff (rst)
      !core_active[c] |=> !arm_o[c]);
    // R9
    a_r9_pause_isolated: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && addr == ADDR_W'(c*32 + 4)) |=> $stable(pause_o[c]));
    a_r9_arm_isolated: assert property (@(posedge clk) disable iff (rst)
      (!(wr_en && addr == ADDR_W'(c*32 + 4)) && core_active[c]) |=> $stable(arm_o[c]));
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (grp == GRP_W'(c)) begin
        if (offs == OFF_CTRL)
          rdata = {22'd0, arm_q[c], paused_q[c], 8'd0};
        else if (offs == OFF_PTR)
          rdata = {8'd0, VERSION, 21'(PTR_BASE + PTR_STEP * c)};
      end
    end
  end

  // R1 / R3 read path: the code field never reads back
  always_comb begin
    if (!rst) a_r3_code_reads_zero: assert (rdata[7:0] == 8'd0);
  end

endmodule

// File: tb/wdog_core_ctl_tb.sv
module wdog_core_ctl_tb_top;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  core_active = '1;
  logic [N-1:0]  pause_o, arm_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] m_pause = '0;
  logic [N-1:0] m_arm   = '0;

  always #5 clk = ~clk;

  wdog_core_ctl #(.NUM_CORES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_active(core_active), .pause_o(pause_o), .arm_o(arm_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    int g = a / 32;
    int o = a % 32;
    if (g >= N) return 32'd0;
    if (o == 4) return {22'd0, m_arm[g], m_pause[g], 8'd0};
    if (o == 8) return 32'h78300 + 32'h100 * g;
    return 32'd0;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    int g = a / 32;
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (g < N && a % 32 == 4) begin
      if (d[8]) m_pause[g] = 1'b0;
      else if (d[7:0] == 8'h76) m_pause[g] = 1'b1;
      if (core_active[g] && d[9]) m_arm[g] = 1'b1;
    end
    for (int c = 0; c < N; c++) if (!core_active[c]) m_arm[c] = 1'b0;
  endtask

  task automatic set_active(input logic [N-1:0] v);
    @(negedge clk);
    core_active = v;
    @(negedge clk);
    for (int c = 0; c < N; c++) if (!v[c]) m_arm[c] = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a);
    addr = AW'(a);
    #1;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic out_chk(input string req);
    chk({req, " pause_o"}, 32'(pause_o), 32'(m_pause));
    chk({req, " arm_o"}, 32'(arm_o), 32'(m_arm));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8 reset state
    out_chk("R8 reset");
    for (int c = 0; c < N; c++) rd_chk("R8 reset ctrl", c * 32 + 4);

    // R1 R2 pointer words, writes ignored
    for (int c = 0; c < N; c++) begin
      rd_chk("R2 pointer", c * 32 + 8);
      chk("R2 pointer literal", rdata, 32'h78300 + 32'h100 * c);
      wr(c * 32 + 8, 32'hFFFF_FFFF);
      rd_chk("R2 pointer after write", c * 32 + 8);
      out_chk("R2 no flag change");
    end

    // R3 R4 sweep of every code value on every core
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k < 256; k++) begin
        wr(c * 32 + 4, 32'h100);
        wr(c * 32 + 4, 32'(k));
        chk(k == 8'h76 ? "R3 key sets pause" : "R4 other code ignored",
            32'(pause_o[c]), 32'(k == 8'h76));
        out_chk("R4 model");
      end
      wr(c * 32 + 4, 32'h76);
      wr(c * 32 + 4, 32'h75);
      chk("R4 code leaves set flag", 32'(pause_o[c]), 32'd1);
      rd_chk("R3 readback bit 8, code reads 0", c * 32 + 4);
    end

    // R5 clear, and clear wins over key
    wr(4, 32'h76);
    wr(4, 32'h176);
    chk("R5 clear wins over key", 32'(pause_o[0]), 32'd0);
    wr(36, 32'h100);
    chk("R5 clear", 32'(pause_o[1]), 32'd0);
    out_chk("R5 model");

    // R6 set and hold
    wr(2 * 32 + 4, 32'h200);
    chk("R6 arm set", 32'(arm_o[2]), 32'd1);
    wr(2 * 32 + 4, 32'h000);
    chk("R6 write 0 holds", 32'(arm_o[2]), 32'd1);
    rd_chk("R6 readback bit 9", 2 * 32 + 4);
    for (int c = 0; c < N; c++) wr(c * 32 + 4, 32'h200);
    out_chk("R6 all armed");

    // R7 inactive clears and overrides set
    set_active(4'b1101);
    chk("R7 inactive clears", 32'(arm_o[1]), 32'd0);
    wr(36, 32'h200);
    chk("R7 inactive blocks set", 32'(arm_o[1]), 32'd0);
    out_chk("R7 others kept");
    set_active(4'b1111);
    chk("R7 stays clear on return", 32'(arm_o[1]), 32'd0);

    // R9 unmapped writes ignored, full read sweep
    wr(3 * 32 + 4, 32'h100);
    for (int a = 0; a < 256; a++) begin
      if (!(a / 32 < N && a % 32 == 4)) wr(a, 32'h0000_0276);
    end
    out_chk("R9 unmapped writes ignored");
    for (int a = 0; a < 256; a++) rd_chk("R1 R9 address sweep", a);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule